// File: doc/BRIEF.md
# Wrapping Register Stack with Occupancy Tags

This block holds eight 80-bit words arranged as a circular stack. A 3-bit top pointer picks the physical slot that counts as the top of the stack. Every other operand is named by its distance from the top: ST(i) is physical slot (top + i) mod 8. The words are opaque, so the block does no arithmetic and no format conversion. A surrounding execution unit reads operands through the ST(i) read port and the top-of-stack output. It then asks for one stack operation per clock: push a new word, pop the top, overwrite any ST(i), or perform a classic step. A classic step stores a result into ST(1) and then pops, so the result becomes the new top.

Each physical slot carries an occupancy tag. A push sets the tag of the slot it fills. A pop or a classic step clears the tag of the slot it leaves. A push onto a slot that is still occupied is refused and reported as an overflow. A pop or classic step that would consume an empty slot is refused and reported as an underflow. A refused operation changes neither the pointer nor any data. The read port also reports whether the slot it addresses is empty. When several operations are requested together, one of them is chosen by a fixed priority.

Top module: `wrap_regstack`

## Requirements
- R1: After reset the top pointer is 0, every slot is empty (rd_empty reads 1 for every rd_idx), and fault_ovf and fault_unf are 0.
- R2: An accepted push moves the top pointer to (top - 1) mod 8, so a push from top 0 gives 7. It stores push_data in that slot and marks the slot occupied. The pushed word is then visible as ST(0).
- R3: top_data always shows the word in ST(0), which is the word a pop consumes. An accepted pop marks that slot empty and moves the top pointer to (top + 1) mod 8, so a pop from top 7 gives 0.
- R4: rd_data shows the word in physical slot (top + rd_idx) mod 8. rd_empty is 1 exactly when that slot is not occupied.
- R5: A write request replaces the word in slot (top + wr_idx) mod 8. It does not move the top pointer, does not change any occupancy tag, and raises no fault.
- R6: An accepted classic step stores classic_res into ST(1), marks the old ST(0) empty and moves the top pointer to (top + 1) mod 8. The result then reads as ST(0).
- R7: A push whose target slot (top - 1) mod 8 is already occupied raises a fault. fault_ovf is 1 for exactly one cycle, at the clock edge that would have performed the push. The pointer, the tags and the data are left unchanged.
- R8: A pop with ST(0) empty, or a classic step with ST(0) or ST(1) empty, raises a fault. fault_unf is 1 for exactly one cycle, at the clock edge that would have performed the operation. The pointer, the tags and the data are left unchanged.
- R9: At most one operation is performed per clock. The priority is classic step (highest), then pop, then push, then write (lowest). Requests that lose have no effect, and fault_ovf and fault_unf are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| push_req | input | 1 | Request to push push_data |
| push_data | input | 80 | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| wr_req | input | 1 | Request to overwrite ST(wr_idx) |
| wr_idx | input | 3 | Stack-relative index of the write |
| wr_data | input | 80 | Word to write |
| classic_req | input | 1 | Request for a classic step (store into ST(1), then pop) |
| classic_res | input | 80 | Result word for the classic step |
| rd_idx | input | 3 | Stack-relative index of the read port |
| rd_data | output | 80 | Word in ST(rd_idx) |
| rd_empty | output | 1 | 1 when ST(rd_idx) is not occupied |
| top_data | output | 80 | Word in ST(0) |
| top_ptr | output | 3 | Current top pointer (physical slot of ST(0)) |
| fault_ovf | output | 1 | One-cycle pulse: a push was refused because its target slot is occupied |
| fault_unf | output | 1 | One-cycle pulse: a pop or classic step was refused because a slot it needs is empty |

## Verification
The hardest case to reach is the wrap of the pointer together with a full stack. An overflow needs all eight slots occupied, and the pointer must run across the 0/7 boundary in both directions while the tags stay consistent. The directed part of the stimulus starts from an empty stack and pushes eight words, which wraps the pointer from 0 to 7 and fills every slot. It then attempts a ninth push and drains the stack through the 7-to-0 wrap. The random part mixes simultaneous requests with push-heavy weights so that the stack fills and empties repeatedly. Every ST(i) read and every fault is checked against a bench model of the pointer and the tags.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  // Operation selected for the current cycle
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_CLASSIC = 3'd1,
    OP_POP     = 3'd2,
    OP_PUSH    = 3'd3,
    OP_WRITE   = 3'd4
  } op_e;
endpackage

// File: rtl/wrs_rst_sync.sv
module wrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/wrs_arbiter.sv
module wrs_arbiter
  import wrs_pkg::*;
(
  input  logic classic_req,
  input  logic pop_req,
  input  logic push_req,
  input  logic wr_req,
  output op_e  op
);
  // Fixed priority: classic step, pop, push, write
  always_comb begin
    if (classic_req)   op = OP_CLASSIC;
    else if (pop_req)  op = OP_POP;
    else if (push_req) op = OP_PUSH;
    else if (wr_req)   op = OP_WRITE;
    else               op = OP_IDLE;
  end
endmodule

// File: rtl/wrs_ptr.sv
module wrs_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [PW-1:0] top_q
);
  logic [PW-1:0] top_nx;
  logic          top_en;

  // Modulo wrap comes from the natural overflow of a PW-bit field
  always_comb begin
    top_en = step_up | step_dn;
    top_nx = top_q;
    if (step_up)      top_nx = top_q + 1'b1;
    else if (step_dn) top_nx = top_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_nx;
  end
endmodule

// File: rtl/wrs_file.sv
module wrs_file #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PW-1:0]               wr_slot,
  input  logic [WIDTH-1:0]            wr_val,
  input  logic                        tag_set,
  input  logic [PW-1:0]               tag_set_slot,
  input  logic                        tag_clr,
  input  logic [PW-1:0]               tag_clr_slot,
  output logic [DEPTH-1:0][WIDTH-1:0] slot_q,
  output logic [DEPTH-1:0]            tag_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             data_en;
    logic [WIDTH-1:0] data_r;
    logic             tag_r;
    logic             tag_nx;

    assign data_en = wr_en && (wr_slot == PW'(g));

    always_comb begin
      tag_nx = tag_r;
      if (tag_clr && (tag_clr_slot == PW'(g))) tag_nx = 1'b0;
      if (tag_set && (tag_set_slot == PW'(g))) tag_nx = 1'b1;
    end

    // Payload needs no reset: an untagged slot is never treated as valid
    always_ff @(posedge clk) begin
      if (data_en) data_r <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_r <= 1'b0;
      else        tag_r <= tag_nx;
    end

    assign slot_q[g] = data_r;
    assign tag_q[g]  = tag_r;
  end
endmodule

// File: rtl/wrap_regstack.sv
module wrap_regstack
  import wrs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  input  logic             wr_req,
  input  logic [PW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             classic_req,
  input  logic [WIDTH-1:0] classic_res,
  input  logic [PW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty,
  output logic [WIDTH-1:0] top_data,
  output logic [PW-1:0]    top_ptr,
  output logic             fault_ovf,
  output logic             fault_unf
);
  logic                        rst_q_n;
  op_e                         op;
  logic [PW-1:0]               top_q;
  logic [DEPTH-1:0][WIDTH-1:0] slot_q;
  logic [DEPTH-1:0]            tag_q;

  // Stack-relative slot addresses
  logic [PW-1:0] st0_slot, st1_slot, below_slot, rd_slot, wr_slot_rel;

  // Next-state controls
  logic             f_wr_en;
  logic [PW-1:0]    f_wr_slot;
  logic [WIDTH-1:0] f_wr_val;
  logic             f_set, f_clr;
  logic [PW-1:0]    f_set_slot, f_clr_slot;
  logic             p_up, p_dn;
  logic             ovf_nx, unf_nx;

  wrs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  wrs_arbiter u_arb (
    .classic_req (classic_req),
    .pop_req     (pop_req),
    .push_req    (push_req),
    .wr_req      (wr_req),
    .op          (op)
  );

  wrs_ptr #(.PW(PW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .step_up (p_up),
    .step_dn (p_dn),
    .top_q   (top_q)
  );

  wrs_file #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_file (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .wr_en        (f_wr_en),
    .wr_slot      (f_wr_slot),
    .wr_val       (f_wr_val),
    .tag_set      (f_set),
    .tag_set_slot (f_set_slot),
    .tag_clr      (f_clr),
    .tag_clr_slot (f_clr_slot),
    .slot_q       (slot_q),
    .tag_q        (tag_q)
  );

  always_comb begin
    st0_slot    = top_q;
    st1_slot    = top_q + 1'b1;
    below_slot  = top_q - 1'b1;
    rd_slot     = top_q + rd_idx;
    wr_slot_rel = top_q + wr_idx;
  end

  // Next-state decode for the single accepted operation
  always_comb begin
    f_wr_en    = 1'b0;
    f_wr_slot  = '0;
    f_wr_val   = '0;
    f_set      = 1'b0;
    f_set_slot = '0;
    f_clr      = 1'b0;
    f_clr_slot = '0;
    p_up       = 1'b0;
    p_dn       = 1'b0;
    ovf_nx     = 1'b0;
    unf_nx     = 1'b0;
    unique case (op)
      OP_CLASSIC: begin
        if (tag_q[st0_slot] && tag_q[st1_slot]) begin
          f_wr_en    = 1'b1;
          f_wr_slot  = st1_slot;
          f_wr_val   = classic_res;
          f_clr      = 1'b1;
          f_clr_slot = st0_slot;
          p_up       = 1'b1;
        end else begin
          unf_nx = 1'b1;
        end
      end
      OP_POP: begin
        if (tag_q[st0_slot]) begin
          f_clr      = 1'b1;
          f_clr_slot = st0_slot;
          p_up       = 1'b1;
        end else begin
          unf_nx = 1'b1;
        end
      end
      OP_PUSH: begin
        if (!tag_q[below_slot]) begin
          f_wr_en    = 1'b1;
          f_wr_slot  = below_slot;
          f_wr_val   = push_data;
          f_set      = 1'b1;
          f_set_slot = below_slot;
          p_dn       = 1'b1;
        end else begin
          ovf_nx = 1'b1;
        end
      end
      OP_WRITE: begin
        f_wr_en   = 1'b1;
        f_wr_slot = wr_slot_rel;
        f_wr_val  = wr_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fault_ovf <= 1'b0;
      fault_unf <= 1'b0;
    end else begin
      fault_ovf <= ovf_nx;
      fault_unf <= unf_nx;
    end
  end

  assign top_ptr  = top_q;
  assign top_data = slot_q[st0_slot];
  assign rd_data  = slot_q[rd_slot];
  assign rd_empty = ~tag_q[rd_slot];
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          wr_req,
  input logic          classic_req,
  input logic [PW-1:0] top_ptr,
  input logic          fault_ovf,
  input logic          fault_unf
);
  a_r2_push_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !classic_req) |=>
      (fault_ovf ? (top_ptr == $past(top_ptr)) : (top_ptr == PW'($past(top_ptr) - 1'b1))));

  a_r3_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !classic_req) |=>
      (fault_unf ? (top_ptr == $past(top_ptr)) : (top_ptr == PW'($past(top_ptr) + 1'b1))));

  a_r6_classic_moves: assert property (@(posedge clk) disable iff (!rst_n)
    classic_req |=>
      (fault_unf ? (top_ptr == $past(top_ptr)) : (top_ptr == PW'($past(top_ptr) + 1'b1))));

  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !push_req && !pop_req && !classic_req) |=>
      ($stable(top_ptr) && !fault_ovf && !fault_unf));

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !push_req && !pop_req && !classic_req) |=>
      ($stable(top_ptr) && !fault_ovf && !fault_unf));

  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ovf |-> $past(push_req && !pop_req && !classic_req));

  a_r8_unf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault_unf |-> $past(pop_req || classic_req));

  a_r9_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_ovf && fault_unf));
endmodule

bind wrap_regstack wrs_chk #(.PW($clog2(DEPTH))) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .wr_req      (wr_req),
  .classic_req (classic_req),
  .top_ptr     (top_ptr),
  .fault_ovf   (fault_ovf),
  .fault_unf   (fault_unf)
);

// File: tb/wrap_regstack_test.sv
module wrap_regstack_test;
  localparam int W  = 80;
  localparam int D  = 8;
  localparam int PW = 3;

  logic          clk;
  logic          rst_n;
  logic          push_req, pop_req, wr_req, classic_req;
  logic [W-1:0]  push_data, wr_data, classic_res;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [W-1:0]  rd_data, top_data;
  logic          rd_empty;
  logic [PW-1:0] top_ptr;
  logic          fault_ovf, fault_unf;

  wrap_regstack #(.DEPTH(D), .WIDTH(W)) uut (
    .clk (clk), .rst_n (rst_n),
    .push_req (push_req), .push_data (push_data),
    .pop_req (pop_req),
    .wr_req (wr_req), .wr_idx (wr_idx), .wr_data (wr_data),
    .classic_req (classic_req), .classic_res (classic_res),
    .rd_idx (rd_idx), .rd_data (rd_data), .rd_empty (rd_empty),
    .top_data (top_data), .top_ptr (top_ptr),
    .fault_ovf (fault_ovf), .fault_unf (fault_unf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Bench model of the stack
  logic [W-1:0]  m_data [D];
  bit            m_tag  [D];
  logic [PW-1:0] m_top;

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  // One cycle: drive at negedge, check combinational reads, apply the model,
  // then check the registered outputs just after the posedge.
  task automatic step(bit c, bit p, bit u, bit w, logic [W-1:0] pd,
                      logic [PW-1:0] wi, logic [W-1:0] wd, logic [W-1:0] rs,
                      logic [PW-1:0] ri, string req);
    logic [PW-1:0] s, n1, nb;
    bit eo, eu;
    @(negedge clk);
    classic_req = c; pop_req = p; push_req = u; wr_req = w;
    push_data = pd; wr_idx = wi; wr_data = wd; classic_res = rs; rd_idx = ri;
    #1;
    s = m_top + ri;
    chk(rd_empty == !m_tag[s], "R4", "rd_empty", W'(rd_empty), W'(!m_tag[s]));
    if (m_tag[s]) chk(rd_data == m_data[s], "R4", "rd_data", rd_data, m_data[s]);
    if (m_tag[m_top]) chk(top_data == m_data[m_top], "R3", "top_data", top_data, m_data[m_top]);
    eo = 1'b0; eu = 1'b0;
    n1 = m_top + 1'b1;
    nb = m_top - 1'b1;
    if (c) begin
      if (m_tag[m_top] && m_tag[n1]) begin
        m_data[n1] = rs; m_tag[m_top] = 1'b0; m_top = n1;
      end else eu = 1'b1;
    end else if (p) begin
      if (m_tag[m_top]) begin m_tag[m_top] = 1'b0; m_top = n1; end
      else eu = 1'b1;
    end else if (u) begin
      if (m_tag[nb]) eo = 1'b1;
      else begin m_data[nb] = pd; m_tag[nb] = 1'b1; m_top = nb; end
    end else if (w) begin
      s = m_top + wi;
      m_data[s] = wd;
    end
    @(posedge clk);
    #1;
    chk(top_ptr == m_top, req, "top_ptr", W'(top_ptr), W'(m_top));
    chk(fault_ovf == eo, req, "fault_ovf", W'(fault_ovf), W'(eo));
    chk(fault_unf == eu, req, "fault_unf", W'(fault_unf), W'(eu));
  endtask

  task automatic idle_read(logic [PW-1:0] ri, string req);
    step(0, 0, 0, 0, '0, '0, '0, '0, ri, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061211));
    rst_n = 1'b0;
    push_req = 0; pop_req = 0; wr_req = 0; classic_req = 0;
    push_data = '0; wr_data = '0; classic_res = '0; wr_idx = '0; rd_idx = '0;
    for (int i = 0; i < D; i++) begin m_tag[i] = 1'b0; m_data[i] = '0; end
    m_top = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(top_ptr == 0, "R1", "top_ptr", W'(top_ptr), W'(0));
    chk(!fault_ovf && !fault_unf, "R1", "faults", W'({fault_ovf, fault_unf}), W'(0));
    for (int i = 0; i < D; i++) begin
      rd_idx = PW'(i); #1;
      chk(rd_empty == 1'b1, "R1", "rd_empty", W'(rd_empty), W'(1));
    end

    // R8: pop and classic step on an empty stack
    step(0, 1, 0, 0, '0, '0, '0, '0, '0, "R8");
    step(1, 0, 0, 0, '0, '0, '0, rnd_word(), '0, "R8");

    // R2: fill all eight slots, first push wraps 0 -> 7
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, rnd_word(), '0, '0, '0, '0, "R2");

    // R7: ninth push overflows
    step(0, 0, 1, 0, rnd_word(), '0, '0, '0, '0, "R7");

    // R4: read every ST(i)
    for (int i = 0; i < D; i++) idle_read(PW'(i), "R4");

    // R5: overwrite ST(3), then read it back
    step(0, 0, 0, 1, '0, 3'd3, rnd_word(), '0, 3'd3, "R5");
    idle_read(3'd3, "R5");

    // R6: classic step, result on top
    step(1, 0, 0, 0, '0, '0, '0, rnd_word(), '0, "R6");
    idle_read(3'd0, "R6");

    // R9: all four requested at once, then pop+push, then push+write
    step(1, 1, 1, 1, rnd_word(), 3'd1, rnd_word(), rnd_word(), 3'd1, "R9");
    step(0, 1, 1, 0, rnd_word(), '0, '0, '0, '0, "R9");
    step(0, 0, 1, 1, rnd_word(), 3'd2, rnd_word(), '0, 3'd2, "R9");
    for (int i = 0; i < D; i++) idle_read(PW'(i), "R9");

    // R3: drain across the 7 -> 0 wrap, then underflow
    while (m_tag[m_top]) step(0, 1, 0, 0, '0, '0, '0, '0, 3'd1, "R3");
    step(0, 1, 0, 0, '0, '0, '0, '0, '0, "R8");

    // R8: classic step with a single occupied slot
    step(0, 0, 1, 0, rnd_word(), '0, '0, '0, '0, "R2");
    step(1, 0, 0, 0, '0, '0, '0, rnd_word(), '0, "R8");
    step(0, 1, 0, 0, '0, '0, '0, '0, '0, "R3");

    // R9: constrained random mix with simultaneous requests
    for (int n = 0; n < 4000; n++) begin
      bit c, p, u, w;
      c = ($urandom % 100) < 10;
      p = ($urandom % 100) < 25;
      u = ($urandom % 100) < 40;
      w = ($urandom % 100) < 20;
      step(c, p, u, w, rnd_word(), PW'($urandom), rnd_word(), rnd_word(),
           PW'($urandom), "R9");
    end
    idle_read(3'd0, "R4");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule